// File: doc/BRIEF.md
# Home Directory Controller for MSI Coherence

This block is the home node of a point-to-point coherence scheme for a small shared-memory system with `NPROC` processors. For each of the `NLINES` cache lines it is home for, it records a line state (Invalid, Shared or Modified), the owning processor while the line is Modified, and a bit vector of the processors holding clean copies. Processors send read or write requests into it. It answers each one with a grant. Only when other caches hold the line does it first send a forward or invalidate message to exactly those caches and wait for their acknowledgements.

While acknowledgements for a line are outstanding, that line is busy. Further requests to it are parked in a small replay queue and served in arrival order once the line settles. Requests to other lines go ahead in the meantime. Data movement, the network and the caches themselves lie outside the block. They appear only as message ports: one request port, one outgoing coherence-message port carrying a destination bit mask, one acknowledgement port, and one grant port.

Top module: `dir_msi_home`

## Requirements
- R1: During and right after reset, every line is Invalid and idle, `gnt_valid` and `msg_valid` are low, and `req_ready` is high.
- R2: A read to an Invalid or Shared line is granted in the cycle after acceptance with `gnt_excl`=0 and `gnt_remote`=0. No message is sent, and the requester is added to the sharer set.
- R3: A write to an Invalid line is granted in the cycle after acceptance with `gnt_excl`=1 and `gnt_remote`=0. The requester becomes owner.
- R4: A read to a line Modified at another processor produces, in the cycle after acceptance, one message with `msg_inv`=0 (forward), `msg_dest` having only bit <owner> set and `msg_rqid` equal to the requester. The grant (`gnt_excl`=0, `gnt_remote`=1) appears in the cycle after the acknowledgement. Both the old owner and the requester are then sharers.
- R5: A write to a Shared line with other sharers sends one message with `msg_inv`=1 and `msg_dest` equal to the sharer set without the requester. Bit i of any destination mask stands for processor i, and a message never targets its own requester. The grant (`gnt_excl`=1, `gnt_remote`=1) appears in the cycle after the last of that many acknowledgements, and not before.
- R6: A write from the only sharer of a Shared line is granted with `gnt_excl`=1 and `gnt_remote`=0 in the cycle after acceptance, with no message.
- R7: A write to a line Modified at another processor sends an invalidate (`msg_inv`=1) to the owner alone. The grant with `gnt_excl`=1 and `gnt_remote`=1 follows the acknowledgement, and the requester becomes owner.
- R8: A request to a busy line is accepted into the replay queue and produces no grant or message until the line's acknowledgements are complete. Queued requests to a line are then served one at a time in arrival order, starting the cycle after the completing grant.
- R9: While one line is busy, a request to a different line that has nothing queued is served without waiting.
- R10: When the replay queue holds `QDEPTH` entries, a request that would have to be queued sees `req_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_wr | input | 1 | 1 = write (exclusive) request, 0 = read request |
| req_line | input | $clog2(NLINES) | Line index |
| ack_valid | input | 1 | One acknowledgement arrives |
| ack_line | input | $clog2(NLINES) | Line the acknowledgement belongs to |
| msg_valid | output | 1 | Coherence message issued this cycle |
| msg_inv | output | 1 | 1 = invalidate, 0 = forward data to requester and drop to Shared |
| msg_dest | output | NPROC | Destination bit mask, bit i = processor i |
| msg_line | output | $clog2(NLINES) | Line of the message |
| msg_rqid | output | $clog2(NPROC) | Processor on whose behalf the message is sent |
| gnt_valid | output | 1 | Grant issued this cycle |
| gnt_dst | output | $clog2(NPROC) | Processor receiving the grant |
| gnt_line | output | $clog2(NLINES) | Granted line |
| gnt_excl | output | 1 | 1 = requester now owns the line in Modified |
| gnt_remote | output | 1 | 1 = grant waited on other caches (three-hop path) |

## Verification
The hardest situation to reach is a busy line whose replay queue already holds a mix of reads and writes. The queued requests then each start their own coherence round trip, one after another, once the blocking transaction completes. The stimulus opens a transaction and withholds the acknowledgement. It piles requests for that line into the queue, up to the point where `req_ready` drops, and slips a request to an unrelated line in between. It then releases the acknowledgements one by one and predicts every forward, invalidate and grant in the order the replays must produce them.

// File: rtl/dir_pkg.sv
// Shared definitions for the home directory controller.
// Assumes: line state fits in two bits; codes are fixed, not parameterized.
package dir_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_M = 2'b10
    } line_st_e;
endpackage

// File: rtl/dir_replay_fifo.sv
// Replay queue for requests that hit a busy line.
// Holds packed {src, wr, line} items in a shift register, oldest at slot 0.
// Assumes: line index occupies the low LW bits of an item; push only when not full.
module dir_replay_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 4,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          head_valid,
    output logic          full,
    input  logic [LW-1:0] probe_line,
    output logic          probe_hit
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]    slot_q [DEPTH];
    logic [CNTW-1:0] cnt_q;
    logic [AW-1:0]   wr_idx;
    logic [DEPTH-1:0] hit_vec;

    // Where an incoming item lands, accounting for a same-cycle pop.
    always_comb wr_idx = AW'(pop ? (cnt_q - CNTW'(1)) : cnt_q);

    // Occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNTW'(push) - CNTW'(pop);
    end

    // Shift on pop, write new item behind the last valid one.
    always_ff @(posedge clk) begin
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) slot_q[i] <= slot_q[i+1];
        end
        if (push) slot_q[wr_idx] <= push_data;
    end

    // Per-slot match of the probed line against valid entries.
    for (genvar g = 0; g < DEPTH; g++) begin : g_probe
        assign hit_vec[g] = (CNTW'(g) < cnt_q) && (slot_q[g][LW-1:0] == probe_line);
    end

    assign probe_hit  = |hit_vec;
    assign head       = slot_q[0];
    assign head_valid = (cnt_q != '0);
    assign full       = (cnt_q == CNTW'(DEPTH));
endmodule

// File: rtl/dir_action.sv
// Combinational protocol decision for one request against one idle line entry.
// Produces the entry's next value, any coherence message and an immediate grant.
// Assumes: the line is not busy; a busy transaction keeps the old state until completion.
module dir_action
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int PW    = 2,
    parameter int CW    = 3
) (
    input  line_st_e         cur_st,
    input  logic [PW-1:0]    cur_own,
    input  logic [NPROC-1:0] cur_shr,
    input  logic [PW-1:0]    rq_src,
    input  logic             rq_wr,
    output line_st_e         nx_st,
    output logic [PW-1:0]    nx_own,
    output logic [NPROC-1:0] nx_shr,
    output logic             go_busy,
    output logic [CW-1:0]    nx_cnt,
    output logic             send_msg,
    output logic             msg_inv,
    output logic [NPROC-1:0] msg_mask,
    output logic             grant_now,
    output logic             grant_excl
);
    logic [NPROC-1:0] src_oh;
    logic [NPROC-1:0] others;
    logic [CW-1:0]    others_cnt;

    assign src_oh = NPROC'(1) << rq_src;
    assign others = cur_shr & ~src_oh;

    // Number of acknowledgements an invalidation of the other sharers will bring.
    always_comb begin
        others_cnt = '0;
        for (int i = 0; i < NPROC; i++) others_cnt = others_cnt + CW'(others[i]);
    end

    // Protocol decision by current line state and request kind.
    always_comb begin
        nx_st      = cur_st;
        nx_own     = cur_own;
        nx_shr     = cur_shr;
        go_busy    = 1'b0;
        nx_cnt     = '0;
        send_msg   = 1'b0;
        msg_inv    = 1'b0;
        msg_mask   = '0;
        grant_now  = 1'b0;
        grant_excl = 1'b0;
        unique case (cur_st)
            ST_S: begin
                if (!rq_wr) begin
                    nx_shr    = cur_shr | src_oh;
                    grant_now = 1'b1;
                end else if (others == '0) begin
                    nx_st      = ST_M;
                    nx_own     = rq_src;
                    nx_shr     = '0;
                    grant_now  = 1'b1;
                    grant_excl = 1'b1;
                end else begin
                    go_busy  = 1'b1;
                    nx_cnt   = others_cnt;
                    send_msg = 1'b1;
                    msg_inv  = 1'b1;
                    msg_mask = others;
                end
            end
            ST_M: begin
                if (cur_own == rq_src) begin
                    grant_now  = 1'b1;
                    grant_excl = 1'b1;
                end else begin
                    go_busy  = 1'b1;
                    nx_cnt   = CW'(1);
                    send_msg = 1'b1;
                    msg_inv  = rq_wr;
                    msg_mask = NPROC'(1) << cur_own;
                end
            end
            default: begin
                grant_now = 1'b1;
                if (rq_wr) begin
                    nx_st      = ST_M;
                    nx_own     = rq_src;
                    nx_shr     = '0;
                    grant_excl = 1'b1;
                end else begin
                    nx_st  = ST_S;
                    nx_shr = src_oh;
                end
            end
        endcase
    end
endmodule

// File: rtl/dir_msi_home.sv
// Home directory controller: per-line MSI state, owner and sharer vector.
// Serves one request per cycle, sends forwards/invalidates only to holders,
// counts acknowledgements per line and parks requests to busy lines for replay.
// Assumes: at most one acknowledgement per cycle; acks only for lines awaiting them.
module dir_msi_home
    import dir_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int NLINES = 8,
    parameter int QDEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [$clog2(NPROC)-1:0]  req_src,
    input  logic                      req_wr,
    input  logic [$clog2(NLINES)-1:0] req_line,
    input  logic                      ack_valid,
    input  logic [$clog2(NLINES)-1:0] ack_line,
    output logic                      msg_valid,
    output logic                      msg_inv,
    output logic [NPROC-1:0]          msg_dest,
    output logic [$clog2(NLINES)-1:0] msg_line,
    output logic [$clog2(NPROC)-1:0]  msg_rqid,
    output logic                      gnt_valid,
    output logic [$clog2(NPROC)-1:0]  gnt_dst,
    output logic [$clog2(NLINES)-1:0] gnt_line,
    output logic                      gnt_excl,
    output logic                      gnt_remote
);
    localparam int PW = $clog2(NPROC);
    localparam int LW = $clog2(NLINES);
    localparam int CW = $clog2(NPROC + 1);
    localparam int IW = PW + 1 + LW;

    line_st_e         st_q   [NLINES];
    logic [PW-1:0]    own_q  [NLINES];
    logic [NPROC-1:0] shr_q  [NLINES];
    logic [CW-1:0]    cnt_q  [NLINES];
    logic [PW-1:0]    preq_q [NLINES];
    logic [NLINES-1:0] busy_q;
    logic [NLINES-1:0] pwr_q;

    logic [IW-1:0] q_head;
    logic          q_valid, q_full, q_hit, q_push;
    logic [PW-1:0] h_src, sv_src;
    logic          h_wr, sv_wr;
    logic [LW-1:0] h_line, sv_line;
    logic          ack_hit, ack_done, replay_go, direct_ok, take_new, serve;

    line_st_e         a_st;
    logic [PW-1:0]    a_own;
    logic [NPROC-1:0] a_shr, a_mask;
    logic [CW-1:0]    a_cnt;
    logic a_busy, a_send, a_inv, a_gnt, a_excl;

    assign {h_src, h_wr, h_line} = q_head;

    // Arbitration: completing ack owns the grant port, then replay, then new requests.
    always_comb begin
        ack_hit   = ack_valid && busy_q[ack_line];
        ack_done  = ack_hit && (cnt_q[ack_line] == CW'(1));
        replay_go = q_valid && !busy_q[h_line] && !ack_done;
        direct_ok = !busy_q[req_line] && !q_hit;
        req_ready = !ack_done && !replay_go && (direct_ok || !q_full);
        take_new  = req_valid && req_ready && direct_ok;
        q_push    = req_valid && req_ready && !direct_ok;
        serve     = replay_go || take_new;
        sv_src    = replay_go ? h_src  : req_src;
        sv_wr     = replay_go ? h_wr   : req_wr;
        sv_line   = replay_go ? h_line : req_line;
    end

    dir_replay_fifo #(.W(IW), .DEPTH(QDEPTH), .LW(LW)) replay_i (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_data({req_src, req_wr, req_line}),
        .pop(replay_go), .head(q_head), .head_valid(q_valid), .full(q_full),
        .probe_line(req_line), .probe_hit(q_hit)
    );

    dir_action #(.NPROC(NPROC), .PW(PW), .CW(CW)) action_i (
        .cur_st(st_q[sv_line]), .cur_own(own_q[sv_line]), .cur_shr(shr_q[sv_line]),
        .rq_src(sv_src), .rq_wr(sv_wr),
        .nx_st(a_st), .nx_own(a_own), .nx_shr(a_shr),
        .go_busy(a_busy), .nx_cnt(a_cnt),
        .send_msg(a_send), .msg_inv(a_inv), .msg_mask(a_mask),
        .grant_now(a_gnt), .grant_excl(a_excl)
    );

    // Directory entries, ack counting, completion and registered message/grant outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) begin
                st_q[i]   <= ST_I;
                own_q[i]  <= '0;
                shr_q[i]  <= '0;
                cnt_q[i]  <= '0;
                preq_q[i] <= '0;
            end
            busy_q <= '0;  pwr_q <= '0;
            msg_valid <= 1'b0; msg_inv <= 1'b0; msg_dest <= '0; msg_line <= '0; msg_rqid <= '0;
            gnt_valid <= 1'b0; gnt_dst <= '0; gnt_line <= '0; gnt_excl <= 1'b0; gnt_remote <= 1'b0;
        end else begin
            msg_valid <= 1'b0;
            gnt_valid <= 1'b0;
            if (ack_hit) cnt_q[ack_line] <= cnt_q[ack_line] - CW'(1);
            if (ack_done) begin
                busy_q[ack_line] <= 1'b0;
                gnt_valid  <= 1'b1;
                gnt_dst    <= preq_q[ack_line];
                gnt_line   <= ack_line;
                gnt_remote <= 1'b1;
                gnt_excl   <= pwr_q[ack_line];
                if (pwr_q[ack_line]) begin
                    st_q[ack_line]  <= ST_M;
                    own_q[ack_line] <= preq_q[ack_line];
                    shr_q[ack_line] <= '0;
                end else begin
                    st_q[ack_line]  <= ST_S;
                    shr_q[ack_line] <= (NPROC'(1) << own_q[ack_line]) |
                                       (NPROC'(1) << preq_q[ack_line]);
                end
            end
            if (serve) begin
                st_q[sv_line]  <= a_st;
                own_q[sv_line] <= a_own;
                shr_q[sv_line] <= a_shr;
                if (a_busy) begin
                    busy_q[sv_line] <= 1'b1;
                    cnt_q[sv_line]  <= a_cnt;
                    preq_q[sv_line] <= sv_src;
                    pwr_q[sv_line]  <= sv_wr;
                end
                if (a_send) begin
                    msg_valid <= 1'b1;
                    msg_inv   <= a_inv;
                    msg_dest  <= a_mask;
                    msg_line  <= sv_line;
                    msg_rqid  <= sv_src;
                end
                if (a_gnt) begin
                    gnt_valid  <= 1'b1;
                    gnt_dst    <= sv_src;
                    gnt_line   <= sv_line;
                    gnt_excl   <= a_excl;
                    gnt_remote <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/dir_msi_home_chk.sv
// Protocol checker for the home directory controller, watching its ports.
// Assumes: reset is synchronous and active low, as in the design.
module dir_msi_home_chk #(
    parameter int NPROC  = 4,
    parameter int NLINES = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      msg_valid,
    input logic                      msg_inv,
    input logic [NPROC-1:0]          msg_dest,
    input logic [$clog2(NLINES)-1:0] msg_line,
    input logic [$clog2(NPROC)-1:0]  msg_rqid,
    input logic                      gnt_valid,
    input logic [$clog2(NLINES)-1:0] gnt_line
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (!gnt_valid && !msg_valid));

    // R4
    fwd_single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_inv) |-> ($countones(msg_dest) == 1));

    // R5
    not_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !msg_dest[msg_rqid]);

    // R5
    holders_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_dest != '0));

    // R8
    no_grant_mid_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && gnt_valid) |-> (msg_line != gnt_line));
endmodule

bind dir_msi_home dir_msi_home_chk #(.NPROC(NPROC), .NLINES(NLINES)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_inv(msg_inv), .msg_dest(msg_dest),
    .msg_line(msg_line), .msg_rqid(msg_rqid),
    .gnt_valid(gnt_valid), .gnt_line(gnt_line)
);

// File: tb/dir_msi_home_tb_top.sv
// Scoreboard bench: stimulus tasks queue expected grants and messages,
// a negedge monitor pops and compares whatever the controller emits.
module dir_msi_home_tb_top;
    localparam int NP = 4, NL = 8, QD = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_wr = 1'b0, ack_valid = 1'b0;
    logic [1:0] req_src = '0;
    logic [2:0] req_line = '0, ack_line = '0;
    logic req_ready, msg_valid, msg_inv, gnt_valid, gnt_excl, gnt_remote;
    logic [3:0] msg_dest;
    logic [2:0] msg_line, gnt_line;
    logic [1:0] msg_rqid, gnt_dst;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [6:0] eg_q[$];  string eg_tag[$];
    logic [9:0] em_q[$];  string em_tag[$];

    always #4 clk = ~clk;

    dir_msi_home #(.NPROC(NP), .NLINES(NL), .QDEPTH(QD)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_wr(req_wr), .req_line(req_line),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .msg_valid(msg_valid), .msg_inv(msg_inv), .msg_dest(msg_dest),
        .msg_line(msg_line), .msg_rqid(msg_rqid),
        .gnt_valid(gnt_valid), .gnt_dst(gnt_dst), .gnt_line(gnt_line),
        .gnt_excl(gnt_excl), .gnt_remote(gnt_remote)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic exp_g(input logic [1:0] d, input logic [2:0] l, input logic x, input logic r, input string tag);
        eg_q.push_back({d, l, x, r});  eg_tag.push_back(tag);
    endtask

    task automatic exp_m(input logic inv, input logic [3:0] dst, input logic [2:0] l, input logic [1:0] rq, input string tag);
        em_q.push_back({inv, dst, l, rq});  em_tag.push_back(tag);
    endtask

    task automatic send_req(input logic [1:0] s, input logic w, input logic [2:0] l);
        @(negedge clk);
        req_valid = 1'b1; req_src = s; req_wr = w; req_line = l;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic send_ack(input logic [2:0] l);
        @(negedge clk);
        ack_valid = 1'b1; ack_line = l;
        @(posedge clk); #1;
        ack_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: compare every emitted grant and message with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (gnt_valid) begin
                if (eg_q.size() == 0) chk(1'b0, "R8 unexpected grant", {gnt_dst, gnt_line, gnt_excl, gnt_remote}, 0);
                else begin
                    logic [6:0] e;  string t;
                    e = eg_q.pop_front();  t = eg_tag.pop_front();
                    chk({gnt_dst, gnt_line, gnt_excl, gnt_remote} == e, t, {gnt_dst, gnt_line, gnt_excl, gnt_remote}, e);
                end
            end
            if (msg_valid) begin
                if (em_q.size() == 0) chk(1'b0, "R5 unexpected message", {msg_inv, msg_dest, msg_line, msg_rqid}, 0);
                else begin
                    logic [9:0] e;  string t;
                    e = em_q.pop_front();  t = em_tag.pop_front();
                    chk({msg_inv, msg_dest, msg_line, msg_rqid} == e, t, {msg_inv, msg_dest, msg_line, msg_rqid}, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            summary();
        end
    end

    initial begin
        idle(3);
        // R1: idle outputs while in reset
        chk(!gnt_valid && !msg_valid, "R1 outputs in reset", {gnt_valid, msg_valid}, 0);
        rst_n = 1'b1;
        idle(1);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

        // R2: reads to Invalid then Shared line 1
        exp_g(0, 1, 0, 0, "R2 read I");   send_req(0, 0, 1);
        exp_g(1, 1, 0, 0, "R2 read S");   send_req(1, 0, 1);
        idle(2);
        // R5: P1 writes, P0 must be invalidated
        exp_m(1, 4'b0001, 1, 1, "R5 inv sharer");  send_req(1, 1, 1);
        idle(4);
        exp_g(1, 1, 1, 1, "R5 grant after ack");   send_ack(1);
        idle(2);
        // R4: P2 reads line Modified at P1
        exp_m(0, 4'b0010, 1, 2, "R4 forward to owner");  send_req(2, 0, 1);
        idle(4);
        exp_g(2, 1, 0, 1, "R4 grant after ack");  send_ack(1);
        idle(2);
        // R4/R5: P3 write must reach both sharers {1,2}, two acks
        exp_m(1, 4'b0110, 1, 3, "R4 both sharers recorded");  send_req(3, 1, 1);
        idle(3);
        send_ack(1);
        idle(3);
        exp_g(3, 1, 1, 1, "R5 grant after last ack");  send_ack(1);
        idle(2);

        // R3: write to Invalid line 2
        exp_g(0, 2, 1, 0, "R3 write I");  send_req(0, 1, 2);
        // R6: sole sharer upgrade on line 3
        exp_g(0, 3, 0, 0, "R2 read I line3");  send_req(0, 0, 3);
        exp_g(0, 3, 1, 0, "R6 upgrade");      send_req(0, 1, 3);
        idle(2);

        // R7: P1 write to line 2 Modified at P0; hold the ack
        exp_m(1, 4'b0001, 2, 1, "R7 inv owner");  send_req(1, 1, 2);
        // R8: two requests to busy line 2 get queued
        send_req(2, 0, 2);
        send_req(3, 1, 2);
        // R9: another line proceeds meanwhile
        exp_g(2, 4, 0, 0, "R9 other line");  send_req(2, 0, 4);
        idle(4);
        exp_g(1, 2, 1, 1, "R7 grant after ack");
        exp_m(0, 4'b0010, 2, 2, "R8 first replay forwards");
        send_ack(2);
        idle(4);
        exp_g(2, 2, 0, 1, "R8 replayed read granted");
        exp_m(1, 4'b0110, 2, 3, "R8 second replay invalidates");
        send_ack(2);
        idle(4);
        send_ack(2);
        idle(2);
        exp_g(3, 2, 1, 1, "R8 replayed write granted");  send_ack(2);
        idle(3);

        // R10: fill the replay queue behind busy line 5
        exp_g(0, 5, 1, 0, "R3 write I line5");  send_req(0, 1, 5);
        exp_m(1, 4'b0001, 5, 1, "R7 inv owner line5");  send_req(1, 1, 5);
        send_req(2, 0, 5);
        send_req(3, 0, 5);
        send_req(2, 0, 5);
        send_req(3, 0, 5);
        @(negedge clk);
        req_valid = 1'b1; req_src = 0; req_wr = 1'b0; req_line = 5;
        #1;
        chk(req_ready == 1'b0, "R10 queue full blocks", req_ready, 0);
        req_valid = 1'b0;
        idle(2);
        exp_g(1, 5, 1, 1, "R7 grant line5");
        exp_m(0, 4'b0010, 5, 2, "R8 replay forward line5");
        send_ack(5);
        idle(4);
        exp_g(2, 5, 0, 1, "R8 replay order 1");
        exp_g(3, 5, 0, 0, "R8 replay order 2");
        exp_g(2, 5, 0, 0, "R8 replay order 3");
        exp_g(3, 5, 0, 0, "R8 replay order 4");
        send_ack(5);
        idle(8);

        chk(eg_q.size() == 0, "R8 grants outstanding", eg_q.size(), 0);
        chk(em_q.size() == 0, "R5 messages outstanding", em_q.size(), 0);
        done = 1'b1;
        summary();
    end
endmodule